// File: doc/BRIEF.md
# Factored Signed-Digit Constant Multiplier

This block multiplies a signed input sample by one fixed, non-negative integer coefficient and uses no hardware multiplier. The coefficient is a parameter. While the design is elaborated, a package function looks for a way to split the coefficient into two factors. It tries every candidate first factor from 2 to 64 that divides the coefficient. Each factor is written in canonical signed-digit form, meaning digits of -1, 0 or +1 with no two non-zero digits side by side. Each factor is then built as a short chain of shifted copies of its operand, which are added or subtracted. The factored form is kept only when it needs fewer adders than writing the whole coefficient in signed-digit form as one flat sum.

When the split is used, two stages run in cascade: the second factor acts on the result of the first factor, not on the original sample. For example, a coefficient of 217 becomes t = 8x - x followed by y = 32t - t. This needs two adders, where the flat form 256 - 32 - 8 + 1 needs three. The price is a longer serial adder path. Every intermediate value is carried at the full product width and is never truncated. The product and its valid flag pass through one output register.

Top module: `facmul`

## Requirements
- R1: While rst_n (asynchronous, active low) is low, out_valid is 0 and out_product is 0.
- R2: out_valid equals the in_valid value from one clock edge earlier.
- R3: When in_valid is 1 at a clock edge, out_product after that edge equals in_sample × COEF as a two's-complement number of PROD_W = DATA_W + ceil(log2(COEF+1)) + 1 bits. This holds for the coefficients 9, 17, 33 and 217.
- R4: When in_valid is 0 at a clock edge, out_product keeps its previous value, even if in_sample changes.
- R5: The extreme inputs -2^(DATA_W-1) and 2^(DATA_W-1)-1 give the exact product, with no truncation or wrap.
- R6: A power-of-two coefficient (16 or 32) gives the exact product, formed as a pure shift with no adder.
- R7: A coefficient of 0 gives a product of 0 for every accepted sample.
- R8: The factor selector returns the first factor of the chosen split, or 1 for the flat form. For each first factor a in 2..64 that divides COEF with a cofactor greater than 1, the cost of the split is the number of non-zero digits in a plus the number in COEF/a, minus 2. The split is taken only if this cost is strictly lower than the flat cost, which is the digit count of COEF minus 1. On a tie, the smaller a wins. The selector returns 7 for 217 and returns 1 for 9 and for 33.
- R9: The digit function returns, for each bit position, a value in {-1, 0, +1}. No two adjacent positions are both non-zero, and the digits weighted by 2^position add up to the value. 217 has 4 non-zero digits, 9 has 2, and 7 and 31 have 2 each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_sample as a sample to multiply |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | in_valid delayed by one clock |
| out_product | output | PROD_W | Signed full-precision product, registered |

## Verification
On every cycle, the bound assertions check the following:
- the cleared outputs during reset;
- the one-cycle delay of the valid flag;
- that the registered product equals a behavioural multiply of the accepted sample;
- that the product holds when no sample is accepted.

These assertions see only the coefficient that the instance was built with. Only the bench's scenarios can show the following:
- the spread of coefficients, running side by side: zero, powers of two, flat forms and the factored cascade;
- the extreme signed inputs;
- the choices made by the elaboration-time factor and digit functions.

// File: rtl/facmul_pkg.sv
package facmul_pkg;

    // Number of bit positions scanned when a value is recoded into signed digits.
    localparam int SCAN_POS = 34;

    // Signed digit (-1, 0, +1) of a non-negative value at bit position pos.
    function automatic int csd_digit(input int value, input int pos);
        int v;
        int d;
        int r;
        v = value;
        r = 0;
        for (int i = 0; i < SCAN_POS; i++) begin
            d = 0;
            if (v[0]) begin
                // Remainder 3 modulo 4 gives digit -1; remainder 1 gives +1.
                d = v[1] ? -1 : 1;
            end
            if (i == pos) begin
                r = d;
            end
            v = (v - d) >>> 1;
        end
        return r;
    endfunction

    // Count of non-zero signed digits of a value.
    function automatic int csd_weight(input int value);
        int n;
        n = 0;
        for (int i = 0; i < SCAN_POS; i++) begin
            if (csd_digit(value, i) != 0) begin
                n++;
            end
        end
        return n;
    endfunction

    // First factor of the cheapest split, or 1 when the flat form is cheaper.
    function automatic int pick_first_factor(input int coef);
        int best;
        int best_cost;
        int cost;
        best = 1;
        best_cost = csd_weight(coef) - 1;
        for (int a = 2; a <= 64; a++) begin
            if ((coef % a) == 0 && (coef / a) > 1) begin
                cost = csd_weight(a) + csd_weight(coef / a) - 2;
                if (cost < best_cost) begin
                    best = a;
                    best_cost = cost;
                end
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/facmul_stage.sv
module facmul_stage
    import facmul_pkg::*;
#(
    parameter int W      = 25,
    parameter int FACTOR = 7
) (
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    // Signed-digit recoding of FACTOR never needs more than one position above its width.
    localparam int NPOS = $clog2(FACTOR + 1) + 1;

    logic signed [W-1:0] acc [NPOS+1];

    assign acc[0] = '0;

    for (genvar k = 0; k < NPOS; k++) begin : g_digit
        localparam int DIG = csd_digit(FACTOR, k);
        if (DIG > 0) begin : g_add
            assign acc[k+1] = acc[k] + (din <<< k);
        end else if (DIG < 0) begin : g_sub
            assign acc[k+1] = acc[k] - (din <<< k);
        end else begin : g_pass
            assign acc[k+1] = acc[k];
        end
    end

    assign dout = acc[NPOS];

endmodule

// File: rtl/facmul.sv
module facmul
    import facmul_pkg::*;
#(
    parameter int  DATA_W = 16,
    parameter int  COEF   = 217,
    localparam int PROD_W = DATA_W + $clog2(COEF + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [PROD_W-1:0] out_product
);

    localparam int FIRST  = pick_first_factor(COEF);
    localparam int STEP_A = (FIRST == 1) ? COEF : FIRST;
    localparam int STEP_B = (FIRST == 1) ? 1 : (COEF / FIRST);

    logic signed [PROD_W-1:0] wide_in;
    logic signed [PROD_W-1:0] mid;
    logic signed [PROD_W-1:0] prod;

    // Sign-extend the sample to full product width before any shift.
    assign wide_in = PROD_W'(in_sample);

    facmul_stage #(
        .W      (PROD_W),
        .FACTOR (STEP_A)
    ) u_step_a (
        .din  (wide_in),
        .dout (mid)
    );

    if (STEP_B == 1) begin : g_flat
        assign prod = mid;
    end else begin : g_cascade
        facmul_stage #(
            .W      (PROD_W),
            .FACTOR (STEP_B)
        ) u_step_b (
            .din  (mid),
            .dout (prod)
        );
    end

    // Valid flag register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Product register, loaded only on accepted samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_product <= '0;
        end else if (in_valid) begin
            out_product <= prod;
        end
    end

endmodule

// File: rtl/facmul_chk.sv
module facmul_chk #(
    parameter int DATA_W = 16,
    parameter int COEF   = 217,
    parameter int PROD_W = 26
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_sample,
    input logic                     out_valid,
    input logic signed [PROD_W-1:0] out_product
);

    logic signed [PROD_W-1:0] ref_prod;
    logic                     rst_seen_q;

    assign ref_prod = PROD_W'(longint'(in_sample) * longint'(COEF));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_seen_q <= 1'b1;
        end else begin
            rst_seen_q <= 1'b0;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n && rst_seen_q === 1'b1) begin
            reset_state_chk: assert (out_valid == 1'b0 && out_product == '0)
                else $error("reset state not cleared");
        end
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    // R3
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_product == $past(ref_prod));

    // R4
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_product));

endmodule

bind facmul facmul_chk #(
    .DATA_W (DATA_W),
    .COEF   (COEF),
    .PROD_W (PROD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sample   (in_sample),
    .out_valid   (out_valid),
    .out_product (out_product)
);

// File: tb/facmul_test.sv
`timescale 1ns/1ps
module facmul_test;
    import facmul_pkg::*;

    localparam int DATA_W = 16;
    localparam int NCOEF  = 7;
    localparam int COEFS [NCOEF] = '{0, 9, 16, 17, 32, 33, 217};
    localparam int MINV = -(1 <<< (DATA_W - 1));
    localparam int MAXV = (1 <<< (DATA_W - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_sample = '0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    for (genvar i = 0; i < NCOEF; i++) begin : g_dut
        localparam int C  = COEFS[i];
        localparam int PW = DATA_W + $clog2(C + 1) + 1;
        logic                 ov;
        logic [PW-1:0]        prod;
        logic                 ev;
        longint               ep;
        bit                   ext_f;
        bit                   held;

        facmul #(.DATA_W(DATA_W), .COEF(C)) uut (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_valid    (in_valid),
            .in_sample   (in_sample),
            .out_valid   (ov),
            .out_product (prod)
        );

        // Behavioural reference: one-cycle delay, plain multiply, hold when idle.
        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ev <= 1'b0; ep <= 0; ext_f <= 1'b0; held <= 1'b0;
            end else begin
                ev <= in_valid;
                held <= !in_valid;
                if (in_valid) begin
                    ep <= longint'(in_sample) * C;
                    ext_f <= (int'(in_sample) == MINV) || (int'(in_sample) == MAXV);
                end
            end
        end

        always @(negedge clk) begin
            string tag;
            longint act;
            act = longint'($signed(prod));
            if (!rst_n) tag = "R1";
            else if (C == 0) tag = "R7";
            else if (C == 16 || C == 32) tag = "R6";
            else if (held) tag = "R4";
            else if (ext_f) tag = "R5";
            else tag = "R3";
            check(act == ep && !$isunknown(prod), $sformatf("%s product coef=%0d", tag, C), act, ep);
            check(ov === ev, $sformatf("%s valid coef=%0d", (!rst_n) ? "R1" : "R2", C),
                  longint'(ov), longint'(ev));
        end
    end

    // Signed-digit property check written independently of the package.
    task automatic digit_check(input int value, input int exp_nz);
        longint sum;
        int nz;
        bit adj;
        sum = 0; nz = 0; adj = 1'b0;
        for (int p = 0; p < 34; p++) begin
            int d;
            d = csd_digit(value, p);
            sum += longint'(d) <<< p;
            if (d != 0) nz++;
            if (p > 0 && d != 0 && csd_digit(value, p - 1) != 0) adj = 1'b1;
        end
        check(sum == value, $sformatf("R9 digit sum of %0d", value), sum, value);
        check(nz == exp_nz, $sformatf("R9 nonzero count of %0d", value), nz, exp_nz);
        check(!adj, $sformatf("R9 adjacency of %0d", value), adj, 0);
    endtask

    task automatic drive(input bit v, input int s);
        @(negedge clk);
        in_valid = v;
        in_sample = DATA_W'(s);
    endtask

    initial begin
        digit_check(217, 4);
        digit_check(7, 2);
        digit_check(31, 2);
        digit_check(9, 2);
        check(pick_first_factor(217) == 7, "R8 split of 217", pick_first_factor(217), 7);
        check(pick_first_factor(9) == 1, "R8 split of 9", pick_first_factor(9), 1);
        check(pick_first_factor(33) == 1, "R8 split of 33", pick_first_factor(33), 1);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 1);
        drive(1, -1);
        drive(1, 100);
        drive(0, 555);      // R4: sample changes while idle
        drive(0, -999);
        drive(1, MAXV);     // R5
        drive(1, MINV);     // R5
        drive(0, 7);
        drive(1, -12345);
        drive(1, 0);
        drive(1, MINV);
        drive(1, MAXV);

        for (int n = 0; n < 300; n++) begin
            drive(($urandom % 4) != 0, int'($signed(DATA_W'($urandom))));
        end

        drive(1, MINV);
        drive(0, MAXV);
        drive(1, MAXV);
        drive(0, 0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule